// File: doc/BRIEF.md
# DMA Channel Address/Count Engine

This block holds the address and transfer-count state for a set of DMA channels and moves it forward one step on every transfer strobe. Each channel keeps a 16-bit working address, a 16-bit working count and a copy of both as reload values. A strobe on a channel moves its address up or down by one, as that channel's direction bit selects, and lowers its count by one. When a strobe finds the count at zero, the count wraps, and this marks terminal count. A channel loaded with N therefore performs N+1 transfers. At terminal count the channel either asks its owner to mask it, or it reloads its working values from the reload copies and stays live.

The block also builds the 24-bit system address for the channel named on the select input. The upper seven address bits come from a page value. In byte mode the working address fills the low 16 bits and the page's lowest bit fills bit 16. In word mode the working address is shifted up one place and bit 0 is zero. Channel 0 alone can freeze its address while still counting. This serves fills and drains to one fixed location.

Request arbitration, bus-cycle timing and the mask register itself belong to neighbouring logic. This block only reports terminal count and mask requests to that logic.

Top module: `dma_xfer_engine`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, every channel's working address and count are zero and `tc_pulse`, `mask_req` and `evt_ch` are zero.
- R2: A cycle with `prog_we` high writes `prog_addr` and `prog_cnt` to both the working and reload copies of channel `prog_ch`. If a strobe names the same channel in that cycle, the strobe is dropped: there is no step and no terminal count.
- R3: A strobe (`xfer` high) on channel `xfer_ch` moves its address by one modulo 2^16. The address goes up when `dir_dec[xfer_ch]`=0 and down when it is 1.
- R4: When `addr_hold`=1, strobes on channel 0 leave its address unchanged but still lower its count. Channels 1 and up ignore `addr_hold`.
- R5: Each strobe lowers the working count by one. A strobe that finds the count at 0000h is terminal count. A channel loaded with N sees terminal count on its (N+1)-th strobe.
- R6: `tc_pulse` is high for exactly the one cycle after the clock edge that takes a terminal-count strobe. `evt_ch` then carries that channel's number until the next terminal count.
- R7: At terminal count with `autoinit[ch]`=0, `mask_req` is high together with `tc_pulse`. The count becomes FFFFh and the address steps as in R3 and R4.
- R8: At terminal count with `autoinit[ch]`=1, `mask_req` stays low and the working address and count are reloaded from the reload copies. Later strobes continue from there.
- R9: With `word_mode`=0, `sys_addr[15:0]` is the working address of channel `xfer_ch`, `sys_addr[16]` is `page[0]`, and `sys_addr[23:17]` is `page[7:1]`.
- R10: With `word_mode`=1, `sys_addr[16:1]` is the working address of channel `xfer_ch`, `sys_addr[0]` is 0, and `sys_addr[23:17]` is `page[7:1]`.
- R11: A strobe or program write on one channel leaves the state of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_mode | input | 1 | 0 selects byte addressing, 1 selects word addressing |
| xfer | input | 1 | Transfer strobe, one step per cycle high |
| xfer_ch | input | 2 | Channel stepped by the strobe and shown on `sys_addr` |
| dir_dec | input | 4 | Per-channel direction, 1 counts the address down |
| autoinit | input | 4 | Per-channel reload-at-terminal-count enable |
| addr_hold | input | 1 | Freezes channel 0's address across strobes |
| prog_we | input | 1 | Writes reload and working values |
| prog_ch | input | 2 | Channel written by `prog_we` |
| prog_addr | input | 16 | Start address to write |
| prog_cnt | input | 16 | Count to write (transfers minus one) |
| page | input | 8 | Page value for the upper address bits |
| sys_addr | output | 24 | System address of channel `xfer_ch` |
| tc_pulse | output | 1 | One-cycle terminal-count indication |
| mask_req | output | 1 | Request to mask the channel in `evt_ch` |
| evt_ch | output | 2 | Channel of the latest terminal count |

## Verification
On every cycle, the assertions check the shape of the address and the relation between the event outputs. The upper bits always follow the page, bit 0 is zero in word mode, and a mask request appears only with terminal count and only on a channel without reload. A held channel 0 also keeps a stable address. Only the bench's scenarios can show transfer counts of N+1, correct reload values after autoinit, address wrap at the 16-bit boundary, and the program write winning over a strobe. The bench compares each of these against its behavioural model on every clock.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

    localparam int ADDR_W = 16;
    localparam int CNT_W  = 16;
    localparam int PAGE_W = 8;
    localparam int SYS_W  = ADDR_W + PAGE_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [PAGE_W-1:0] page_t;
    typedef logic [SYS_W-1:0]  sys_addr_t;

    typedef enum logic {
        WIDTH_BYTE = 1'b0,
        WIDTH_WORD = 1'b1
    } xfer_width_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } addr_dir_e;

    typedef struct packed {
        addr_t work_addr;
        cnt_t  work_cnt;
        addr_t rld_addr;
        cnt_t  rld_cnt;
    } chan_state_t;

    function automatic addr_t next_addr(addr_t a, addr_dir_e dir, logic freeze);
        addr_t r;
        if (freeze)
            r = a;
        else if (dir == DIR_DOWN)
            r = a - addr_t'(1);
        else
            r = a + addr_t'(1);
        return r;
    endfunction

    function automatic sys_addr_t build_sys_addr(addr_t a, page_t p, xfer_width_e w);
        sys_addr_t r;
        if (w == WIDTH_WORD)
            r = {p[PAGE_W-1:1], a, 1'b0};
        else
            r = {p[PAGE_W-1:1], p[0], a};
        return r;
    endfunction

endpackage

// File: rtl/dma_eng_chan.sv
module dma_eng_chan
    import dma_eng_pkg::*;
#(
    parameter bit HOLD_OK = 1'b0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  step,
    input  logic  load,
    input  logic  dir_down,
    input  logic  reload_en,
    input  logic  hold_req,
    input  addr_t ld_addr,
    input  cnt_t  ld_cnt,
    output addr_t cur_addr,
    output logic  tc_hit
);

    chan_state_t st;
    logic        freeze;
    logic        at_zero;
    addr_dir_e   dir;

    generate
        if (HOLD_OK) begin : g_hold
            assign freeze = hold_req;
        end else begin : g_nohold
            assign freeze = 1'b0;
        end
    endgenerate

    assign dir     = dir_down ? DIR_DOWN : DIR_UP;
    assign at_zero = (st.work_cnt == '0);
    assign tc_hit  = step && !load && at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (load) begin
            st.work_addr <= ld_addr;
            st.rld_addr  <= ld_addr;
            st.work_cnt  <= ld_cnt;
            st.rld_cnt   <= ld_cnt;
        end else if (step) begin
            if (at_zero && reload_en) begin
                st.work_addr <= st.rld_addr;
                st.work_cnt  <= st.rld_cnt;
            end else begin
                st.work_addr <= next_addr(st.work_addr, dir, freeze);
                st.work_cnt  <= st.work_cnt - cnt_t'(1);
            end
        end
    end

    assign cur_addr = st.work_addr;

endmodule

// File: rtl/dma_eng_addr_out.sv
module dma_eng_addr_out
    import dma_eng_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  addr_t           ch_addr [NUM_CH],
    input  logic [CH_W-1:0] sel,
    input  page_t           page,
    input  logic            word_mode,
    output sys_addr_t       sys_addr
);

    addr_t       picked;
    xfer_width_e width;

    always_comb begin
        picked = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (sel == CH_W'(i))
                picked = ch_addr[i];
        end
    end

    assign width    = word_mode ? WIDTH_WORD : WIDTH_BYTE;
    assign sys_addr = build_sys_addr(picked, page, width);

endmodule

// File: rtl/dma_eng_evt.sv
module dma_eng_evt #(
    parameter int NUM_CH = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] tc_vec,
    input  logic [NUM_CH-1:0] reload_en,
    output logic              tc_pulse,
    output logic              mask_req,
    output logic [CH_W-1:0]   evt_ch
);

    logic            any_tc;
    logic            no_reload;
    logic [CH_W-1:0] tc_idx;

    always_comb begin
        any_tc    = |tc_vec;
        no_reload = 1'b0;
        tc_idx    = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (tc_vec[i]) begin
                tc_idx    = CH_W'(i);
                no_reload = !reload_en[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tc_pulse <= 1'b0;
            mask_req <= 1'b0;
            evt_ch   <= '0;
        end else begin
            tc_pulse <= any_tc;
            mask_req <= any_tc && no_reload;
            if (any_tc)
                evt_ch <= tc_idx;
        end
    end

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
    import dma_eng_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_mode,
    input  logic              xfer,
    input  logic [CH_W-1:0]   xfer_ch,
    input  logic [NUM_CH-1:0] dir_dec,
    input  logic [NUM_CH-1:0] autoinit,
    input  logic              addr_hold,
    input  logic              prog_we,
    input  logic [CH_W-1:0]   prog_ch,
    input  logic [15:0]       prog_addr,
    input  logic [15:0]       prog_cnt,
    input  logic [7:0]        page,
    output logic [23:0]       sys_addr,
    output logic              tc_pulse,
    output logic              mask_req,
    output logic [CH_W-1:0]   evt_ch
);

    addr_t             ch_addr [NUM_CH];
    logic [NUM_CH-1:0] tc_vec;
    sys_addr_t         sys_w;

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            dma_eng_chan #(
                .HOLD_OK (g == 0)
            ) u_chan (
                .clk       (clk),
                .rst       (rst),
                .step      (xfer && (xfer_ch == CH_W'(g))),
                .load      (prog_we && (prog_ch == CH_W'(g))),
                .dir_down  (dir_dec[g]),
                .reload_en (autoinit[g]),
                .hold_req  (addr_hold),
                .ld_addr   (addr_t'(prog_addr)),
                .ld_cnt    (cnt_t'(prog_cnt)),
                .cur_addr  (ch_addr[g]),
                .tc_hit    (tc_vec[g])
            );
        end
    endgenerate

    dma_eng_addr_out #(
        .NUM_CH (NUM_CH)
    ) u_addr (
        .ch_addr   (ch_addr),
        .sel       (xfer_ch),
        .page      (page_t'(page)),
        .word_mode (word_mode),
        .sys_addr  (sys_w)
    );

    assign sys_addr = sys_w;

    dma_eng_evt #(
        .NUM_CH (NUM_CH)
    ) u_evt (
        .clk       (clk),
        .rst       (rst),
        .tc_vec    (tc_vec),
        .reload_en (autoinit),
        .tc_pulse  (tc_pulse),
        .mask_req  (mask_req),
        .evt_ch    (evt_ch)
    );

endmodule

// File: rtl/dma_eng_chk.sv
module dma_eng_chk #(
    parameter int NUM_CH = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst,
    input logic              word_mode,
    input logic              xfer,
    input logic [CH_W-1:0]   xfer_ch,
    input logic [NUM_CH-1:0] autoinit,
    input logic              addr_hold,
    input logic              prog_we,
    input logic [CH_W-1:0]   prog_ch,
    input logic [7:0]        page,
    input logic [23:0]       sys_addr,
    input logic              tc_pulse,
    input logic              mask_req
);

    // terminal count only follows a strobe that the program write did not override
    assert_tc_after_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        tc_pulse |-> ($past(xfer) && !($past(prog_we) && $past(prog_ch) == $past(xfer_ch))));

    assert_mask_with_tc_R7: assert property (@(posedge clk) disable iff (rst)
        mask_req |-> tc_pulse);

    assert_no_mask_autoinit_R8: assert property (@(posedge clk) disable iff (rst)
        mask_req |-> !$past(autoinit[xfer_ch]));

    assert_page_bits_R9: assert property (@(posedge clk) disable iff (rst)
        sys_addr[23:17] == page[7:1]);

    assert_byte_bit16_R9: assert property (@(posedge clk) disable iff (rst)
        !word_mode |-> sys_addr[16] == page[0]);

    assert_word_bit0_R10: assert property (@(posedge clk) disable iff (rst)
        word_mode |-> sys_addr[0] == 1'b0);

    assert_hold_ch0_R4: assert property (@(posedge clk) disable iff (rst)
        (xfer && xfer_ch == '0 && addr_hold && !prog_we)
        |=> (xfer_ch != '0 || !$stable(word_mode) || !$stable(page) || $stable(sys_addr)));

endmodule

bind dma_xfer_engine dma_eng_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .word_mode (word_mode),
    .xfer      (xfer),
    .xfer_ch   (xfer_ch),
    .autoinit  (autoinit),
    .addr_hold (addr_hold),
    .prog_we   (prog_we),
    .prog_ch   (prog_ch),
    .page      (page),
    .sys_addr  (sys_addr),
    .tc_pulse  (tc_pulse),
    .mask_req  (mask_req)
);

// File: tb/tb_dma_xfer_engine.sv
module tb_dma_xfer_engine;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        word_mode;
    logic        xfer;
    logic [1:0]  xfer_ch;
    logic [3:0]  dir_dec;
    logic [3:0]  autoinit;
    logic        addr_hold;
    logic        prog_we;
    logic [1:0]  prog_ch;
    logic [15:0] prog_addr;
    logic [15:0] prog_cnt;
    logic [7:0]  page;
    logic [23:0] sys_addr;
    logic        tc_pulse;
    logic        mask_req;
    logic [1:0]  evt_ch;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    string tag = "R1";

    // behavioural reference state
    int m_addr [4];
    int m_cnt  [4];
    int m_raddr[4];
    int m_rcnt [4];
    bit m_tc, m_mask;
    int m_evt;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_xfer_engine dut (
        .clk(clk), .rst(rst), .word_mode(word_mode), .xfer(xfer), .xfer_ch(xfer_ch),
        .dir_dec(dir_dec), .autoinit(autoinit), .addr_hold(addr_hold),
        .prog_we(prog_we), .prog_ch(prog_ch), .prog_addr(prog_addr), .prog_cnt(prog_cnt),
        .page(page), .sys_addr(sys_addr), .tc_pulse(tc_pulse), .mask_req(mask_req),
        .evt_ch(evt_ch)
    );

    task automatic model_edge();
        bit t = 0;
        bit mk = 0;
        if (rst) begin
            for (int c = 0; c < 4; c++) begin
                m_addr[c] = 0; m_cnt[c] = 0; m_raddr[c] = 0; m_rcnt[c] = 0;
            end
            m_tc = 0; m_mask = 0; m_evt = 0;
            return;
        end
        for (int c = 0; c < 4; c++) begin
            if (prog_we && prog_ch == c) begin
                m_addr[c] = prog_addr; m_raddr[c] = prog_addr;
                m_cnt[c]  = prog_cnt;  m_rcnt[c]  = prog_cnt;
            end else if (xfer && xfer_ch == c) begin
                if (m_cnt[c] == 0) begin
                    t = 1;
                    mk = !autoinit[c];
                    m_evt = c;
                end
                if (m_cnt[c] == 0 && autoinit[c]) begin
                    m_addr[c] = m_raddr[c];
                    m_cnt[c]  = m_rcnt[c];
                end else begin
                    m_cnt[c] = (m_cnt[c] + 65535) % 65536;
                    if (!(c == 0 && addr_hold))
                        m_addr[c] = dir_dec[c] ? (m_addr[c] + 65535) % 65536
                                               : (m_addr[c] + 1) % 65536;
                end
            end
        end
        m_tc = t;
        m_mask = mk;
    endtask

    function automatic logic [23:0] exp_sys();
        logic [15:0] a = 16'(m_addr[xfer_ch]);
        if (word_mode) return {page[7:1], a, 1'b0};
        return {page[7:1], page[0], a};
    endfunction

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("sys_addr", 32'(sys_addr), 32'(exp_sys()));
        chk("tc_pulse", 32'(tc_pulse), 32'(m_tc));
        chk("mask_req", 32'(mask_req), 32'(m_mask));
        chk("evt_ch",   32'(evt_ch),   32'(m_evt));
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic prog(int ch, int a, int n);
        prog_we = 1; prog_ch = 2'(ch); prog_addr = 16'(a); prog_cnt = 16'(n);
        cyc();
        prog_we = 0;
    endtask

    task automatic strobe(int ch);
        xfer = 1; xfer_ch = 2'(ch);
        cyc();
        xfer = 0;
    endtask

    initial begin
        rst = 1; word_mode = 0; xfer = 0; xfer_ch = 0; dir_dec = 0; autoinit = 0;
        addr_hold = 0; prog_we = 0; prog_ch = 0; prog_addr = 0; prog_cnt = 0; page = 8'h00;
        @(negedge clk);
        tag = "R1";
        cyc(); cyc();
        rst = 0;
        cyc();
        chk("reset tc", 32'(tc_pulse), 0);

        tag = "R2";
        prog(0, 16'h8000, 3);
        prog(1, 16'h1234, 2);
        prog(2, 16'h0010, 0);
        prog(3, 16'hFFFF, 1);
        for (int c = 0; c < 4; c++) begin xfer_ch = 2'(c); #1; chk("loaded addr", 32'(sys_addr[15:0]), 32'(m_addr[c])); end

        // R3 R5 R6 R7: count of strobes to terminal count on channel 1 (loaded 2)
        tag = "R5";
        begin
            int n = 0;
            bit seen = 0;
            for (int k = 0; k < 6 && !seen; k++) begin
                strobe(1);
                n++;
                if (tc_pulse) seen = 1;
            end
            chk("R5 transfers to tc", 32'(n), 3);
        end
        tag = "R7";
        chk("R7 mask with tc", 32'(mask_req), 1);
        chk("R6 evt_ch", 32'(evt_ch), 1);
        cyc();
        chk("R6 one cycle pulse", 32'(tc_pulse), 0);

        // R3 decrement plus R8 autoinit on channel 3
        tag = "R8";
        dir_dec[3] = 1; autoinit[3] = 1;
        for (int k = 0; k < 5; k++) strobe(3);
        cyc();

        // R3 wrap upward on channel 3
        tag = "R3";
        dir_dec[3] = 0; autoinit[3] = 0;
        prog(3, 16'hFFFE, 10);
        for (int k = 0; k < 3; k++) strobe(3);

        // R4 hold on channel 0, other channels keep stepping
        tag = "R4";
        addr_hold = 1;
        for (int k = 0; k < 3; k++) strobe(0);
        strobe(2);
        strobe(2);
        strobe(0);
        addr_hold = 0;
        strobe(0);

        // R9 byte mode addressing with page
        tag = "R9";
        page = 8'hA5; word_mode = 0;
        for (int c = 0; c < 4; c++) begin xfer_ch = 2'(c); cyc(); end
        strobe(1);

        // R10 word mode addressing
        tag = "R10";
        word_mode = 1; page = 8'h5A;
        for (int c = 0; c < 4; c++) begin xfer_ch = 2'(c); cyc(); end
        strobe(3);
        word_mode = 0;

        // R2 program write wins over strobe on same channel
        tag = "R2";
        prog_we = 1; prog_ch = 2; prog_addr = 16'h4444; prog_cnt = 0;
        xfer = 1; xfer_ch = 2;
        cyc();
        prog_we = 0; xfer = 0;
        chk("R2 no tc on overridden strobe", 32'(tc_pulse), 0);
        chk("R2 written addr", 32'(sys_addr[15:0]), 32'h4444);

        // R11 interleaved channels, with autoinit on channel 2
        tag = "R11";
        autoinit[2] = 1; dir_dec[1] = 1;
        prog(1, 16'h0001, 4);
        for (int k = 0; k < 8; k++) strobe(k % 3);
        for (int c = 0; c < 4; c++) begin xfer_ch = 2'(c); cyc(); end

        tag = "R1";
        rst = 1; cyc(); rst = 0; cyc();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule